// File: doc/BRIEF.md
# Host Adapter Control Register

This block is a 16-bit control and status register that a host processor uses to steer a network adapter controller. A write strobe and a write-data bus update the register on the rising clock edge, and a read-data bus shows the whole register at all times. Each bit has its own access rule. Some bits are read-only. Some are plain read/write. One can only be set. A group is writable only while the adapter-reset bit is already 1. Several bits take their reset values from configuration pins. All of these rules apply at the same time to each write.

The register also shows three network-type strap pins live and decodes them into a network-type code. It also holds a small pseudo-DMA handshake. Once pseudo-DMA is enabled, software takes the place of the external hold-acknowledge input. An internal request pulse raises a request flag, and software acknowledges it through a hold bit. While the request is unanswered and interrupts are enabled, an interrupt output is raised.

The read/write port is a plain single-cycle register interface with no valid/ready handshake and no back-pressure. Every strobed write is taken in the cycle it appears, and reads have no side effects.

Top module: `hac_ctrl_reg`

## Requirements
- R1: When `rst_n` is sampled low, the register loads its reset values, as follows:
  - bits 4, 6, 7, 8, 11 and 14 become 0;
  - bits 12 and 15 become 1;
  - bits 9 and 10 take the level of `boot_strap`;
  - bit 13 takes the level of `parity_strap`.
- R2: Bits 2:0 of `rd_data` always equal `strap_net[2:0]` (bit 0 = first strap pin). Bit 3 always reads 0. Writes to bits 3:0 have no effect.
- R3: `net_type` decodes the straps, with s = `strap_net`:
  - s[2]=0 gives 0 (reserved);
  - s[0]=0, s[1]=0 gives 1 (full-duplex Ethernet);
  - s[0]=0, s[1]=1 gives 2 (16 Mbps token ring);
  - s[0]=1, s[1]=0 gives 3 (half-duplex Ethernet);
  - s[0]=1, s[1]=1 gives 4 (4 Mbps token ring).
- R4: Bits 9, 10, 13, 14 and 15 take the write data only when bit 8 (adapter reset) was 1 before that write. Otherwise the write leaves them unchanged.
- R5: Bit 7 (pseudo-DMA enable) is set-only. A write with data bit 7 = 1 sets it, a write with 0 leaves it as it is, and only reset clears it.
- R6: Bits 8 (adapter reset), 11 and 12 (interrupt enable) load the write data on every write.
- R7: Bit 4 (software hold) is written like the bits of R4, but it is loaded with data bit 4 AND the old value of bit 7. It can therefore never be 1 while bit 7 is 0.
- R8: `hold_ack_eff` follows `hw_hold_ack` while bit 7 is 0. While bit 7 is 1 it equals bit 4, and `hw_hold_ack` is ignored.
- R9: Bit 6 (software request) is read-only. It is set by a `dma_req` pulse while bit 7 is 1. It is cleared by a `dma_done` pulse, or by a write with data bit 8 = 1. When a set and a clear arrive in the same cycle, the clear wins.
- R10: `dma_irq` is 1 exactly when bit 6 is 1, bit 4 is 0 and bit 12 is 1.
- R11: Bit 5 (transfer direction) is read-only and always shows the `xfer_dir` input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Current register contents |
| strap_net | input | 3 | Network-type strap pins |
| boot_strap | input | 1 | Reset value source for bits 9 and 10 |
| parity_strap | input | 1 | Reset value source for bit 13 |
| xfer_dir | input | 1 | Pseudo-DMA direction, shown in bit 5 |
| hw_hold_ack | input | 1 | External hold acknowledge |
| dma_req | input | 1 | Internal pseudo-DMA request pulse |
| dma_done | input | 1 | Internal pseudo-DMA completion pulse |
| hold_ack_eff | output | 1 | Hold acknowledge as seen by the adapter |
| dma_irq | output | 1 | Pseudo-DMA interrupt |
| net_type | output | 3 | Decoded network type |

## Verification
The bench builds the block with its default bit map, which is the only configuration it has. It sweeps the following:
- all four combinations of the two reset straps;
- all eight strap codes, each with both transfer directions;
- a few hundred pseudo-random writes, request pulses and completion pulses.

The first stretch of writes keeps pseudo-DMA disabled, so the gated hold bit and the pass-through of the external acknowledge are tested. The later writes then set the enable bit, and the reset-only rule and the request flag are tested with the enable bit on. Every cycle is compared against a field-by-field model of the write rules. A directed case sets and clears the request flag in the same cycle to show that the clear takes priority.

// File: rtl/hac_pkg.sv
package hac_pkg;
  localparam int REG_W   = 16;
  localparam int STRAP_W = 3;

  localparam int B_HLDA   = 4;
  localparam int B_DIR    = 5;
  localparam int B_HRQ    = 6;
  localparam int B_PSD    = 7;
  localparam int B_ARST   = 8;
  localparam int B_HALT   = 9;
  localparam int B_BOOT   = 10;
  localparam int B_LBP    = 11;
  localparam int B_SINTEN = 12;
  localparam int B_PEN    = 13;
  localparam int B_NSEL0  = 14;
  localparam int B_NSEL1  = 15;

  localparam logic [REG_W-1:0] RW_MASK   = (16'd1 << B_ARST) | (16'd1 << B_LBP) | (16'd1 << B_SINTEN);
  localparam logic [REG_W-1:0] LOCK_MASK = (16'd1 << B_HALT) | (16'd1 << B_BOOT) | (16'd1 << B_PEN)
                                         | (16'd1 << B_NSEL0) | (16'd1 << B_NSEL1);

  typedef enum logic [2:0] {
    NET_RSVD   = 3'd0,
    NET_ETH_FD = 3'd1,
    NET_TR16   = 3'd2,
    NET_ETH_HD = 3'd3,
    NET_TR4    = 3'd4
  } net_kind_t;
endpackage

// File: rtl/hac_net_decode.sv
module hac_net_decode
  import hac_pkg::*;
(
  input  logic [STRAP_W-1:0] strap,
  output net_kind_t          kind
);
  always_comb begin
    if (!strap[2]) begin
      kind = NET_RSVD;
    end else begin
      unique case ({strap[0], strap[1]})
        2'b00:   kind = NET_ETH_FD;
        2'b01:   kind = NET_TR16;
        2'b10:   kind = NET_ETH_HD;
        default: kind = NET_TR4;
      endcase
    end
  end
endmodule

// File: rtl/hac_cfg_bits.sv
module hac_cfg_bits
  import hac_pkg::*;
#(
  parameter int                W      = REG_W,
  parameter logic [REG_W-1:0]  RW_M   = RW_MASK,
  parameter logic [REG_W-1:0]  LOCK_M = LOCK_MASK,
  parameter int                GATE_B = B_ARST
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wd,
  input  logic [W-1:0] rst_val,
  output logic [W-1:0] q
);
  logic unused_w;
  assign unused_w = ^(wd & ~(RW_M | LOCK_M)) ^ ^(rst_val & ~(RW_M | LOCK_M));

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (RW_M[i]) begin : g_rw
      always_ff @(posedge clk) begin
        if (!rst_n)  q[i] <= rst_val[i];
        else if (we) q[i] <= wd[i];
      end
    end else if (LOCK_M[i]) begin : g_lock
      always_ff @(posedge clk) begin
        if (!rst_n)              q[i] <= rst_val[i];
        else if (we && q[GATE_B]) q[i] <= wd[i];
      end
    end else begin : g_none
      assign q[i] = 1'b0;
    end
  end
endmodule

// File: rtl/hac_dma_hs.sv
module hac_dma_hs (
  input  logic clk,
  input  logic rst_n,
  input  logic we,
  input  logic wd_hlda,
  input  logic wd_psd,
  input  logic wd_arst,
  input  logic arst_q,
  input  logic sinten,
  input  logic req,
  input  logic done,
  input  logic hw_hold_ack,
  output logic psd_en,
  output logic sw_hlda,
  output logic sw_hrq,
  output logic hold_ack_eff,
  output logic irq
);
  logic hrq_clr, hrq_set;

  assign hrq_clr = done | (we & wd_arst);
  assign hrq_set = req & psd_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      psd_en  <= 1'b0;
      sw_hlda <= 1'b0;
      sw_hrq  <= 1'b0;
    end else begin
      if (we && wd_psd)  psd_en  <= 1'b1;
      if (we && arst_q)  sw_hlda <= wd_hlda & psd_en;
      if (hrq_clr)       sw_hrq  <= 1'b0;
      else if (hrq_set)  sw_hrq  <= 1'b1;
    end
  end

  assign hold_ack_eff = psd_en ? sw_hlda : hw_hold_ack;
  assign irq          = sw_hrq & ~sw_hlda & sinten;
endmodule

// File: rtl/hac_ctrl_reg.sv
module hac_ctrl_reg
  import hac_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [REG_W-1:0]   wr_data,
  output logic [REG_W-1:0]   rd_data,
  input  logic [STRAP_W-1:0] strap_net,
  input  logic               boot_strap,
  input  logic               parity_strap,
  input  logic               xfer_dir,
  input  logic               hw_hold_ack,
  input  logic               dma_req,
  input  logic               dma_done,
  output logic               hold_ack_eff,
  output logic               dma_irq,
  output logic [2:0]         net_type
);
  logic [REG_W-1:0] cfg_q, cfg_rst;
  logic             psd_en, sw_hlda, sw_hrq;
  net_kind_t        kind;

  always_comb begin
    cfg_rst           = '0;
    cfg_rst[B_SINTEN] = 1'b1;
    cfg_rst[B_NSEL1]  = 1'b1;
    cfg_rst[B_HALT]   = boot_strap;
    cfg_rst[B_BOOT]   = boot_strap;
    cfg_rst[B_PEN]    = parity_strap;
  end

  hac_cfg_bits u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (wr_en),
    .wd      (wr_data),
    .rst_val (cfg_rst),
    .q       (cfg_q)
  );

  hac_dma_hs u_dma (
    .clk          (clk),
    .rst_n        (rst_n),
    .we           (wr_en),
    .wd_hlda      (wr_data[B_HLDA]),
    .wd_psd       (wr_data[B_PSD]),
    .wd_arst      (wr_data[B_ARST]),
    .arst_q       (cfg_q[B_ARST]),
    .sinten       (cfg_q[B_SINTEN]),
    .req          (dma_req),
    .done         (dma_done),
    .hw_hold_ack  (hw_hold_ack),
    .psd_en       (psd_en),
    .sw_hlda      (sw_hlda),
    .sw_hrq       (sw_hrq),
    .hold_ack_eff (hold_ack_eff),
    .irq          (dma_irq)
  );

  hac_net_decode u_dec (
    .strap (strap_net),
    .kind  (kind)
  );

  assign net_type = kind;

  always_comb begin
    rd_data          = cfg_q;
    rd_data[STRAP_W-1:0] = strap_net;
    rd_data[3]       = 1'b0;
    rd_data[B_HLDA]  = sw_hlda;
    rd_data[B_DIR]   = xfer_dir;
    rd_data[B_HRQ]   = sw_hrq;
    rd_data[B_PSD]   = psd_en;
  end
endmodule

// File: rtl/hac_ctrl_reg_chk.sv
module hac_ctrl_reg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] rd_data,
  input logic [2:0]  strap_net,
  input logic        hw_hold_ack,
  input logic        hold_ack_eff,
  input logic        dma_irq
);
  AST_STRAP_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[2:0] == strap_net && !rd_data[3]);                       // R2
  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[8] |=> $stable({rd_data[15:13], rd_data[10:9], rd_data[4]})); // R4
  AST_PSD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[7] |=> rd_data[7]);                                      // R5
  AST_HLDA_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[4] |-> rd_data[7]);                                      // R7
  AST_HOLD_SW: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[7] |-> hold_ack_eff == rd_data[4]);                      // R8
  AST_HOLD_HW: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[7] |-> hold_ack_eff == hw_hold_ack);                    // R8
  AST_IRQ_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    dma_irq |-> rd_data[6] && rd_data[12] && !rd_data[4]);           // R10
endmodule

bind hac_ctrl_reg hac_ctrl_reg_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rd_data      (rd_data),
  .strap_net    (strap_net),
  .hw_hold_ack  (hw_hold_ack),
  .hold_ack_eff (hold_ack_eff),
  .dma_irq      (dma_irq)
);

// File: tb/hac_ctrl_reg_bench.sv
`timescale 1ns/1ps
module hac_ctrl_reg_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic [2:0]  strap_net = 3'b100;
  logic        boot_strap = 1'b0, parity_strap = 1'b0, xfer_dir = 1'b0;
  logic        hw_hold_ack = 1'b0, dma_req = 1'b0, dma_done = 1'b0;
  logic        hold_ack_eff, dma_irq;
  logic [2:0]  net_type;

  int checks = 0, fails = 0;
  logic m_hlda, m_hrq, m_psd, m_arst, m_halt, m_boot, m_lbp, m_sint, m_pen, m_n0, m_n1;
  logic [15:0] lf = 16'hACE1;

  always #10 clk = ~clk;

  hac_ctrl_reg u_hac_ctrl_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .strap_net(strap_net), .boot_strap(boot_strap), .parity_strap(parity_strap),
    .xfer_dir(xfer_dir), .hw_hold_ack(hw_hold_ack), .dma_req(dma_req), .dma_done(dma_done),
    .hold_ack_eff(hold_ack_eff), .dma_irq(dma_irq), .net_type(net_type)
  );

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R2 straps",     {13'd0, rd_data[2:0]}, {13'd0, strap_net});
    chk("R2 bit3",       {15'd0, rd_data[3]}, 16'd0);
    chk("R11 dir",       {15'd0, rd_data[5]}, {15'd0, xfer_dir});
    chk("R4 locked",     {11'd0, rd_data[15], rd_data[14], rd_data[13], rd_data[10], rd_data[9]},
                         {11'd0, m_n1, m_n0, m_pen, m_boot, m_halt});
    chk("R5 psdmaen",    {15'd0, rd_data[7]}, {15'd0, m_psd});
    chk("R6 rw bits",    {13'd0, rd_data[12], rd_data[11], rd_data[8]}, {13'd0, m_sint, m_lbp, m_arst});
    chk("R7 swhlda",     {15'd0, rd_data[4]}, {15'd0, m_hlda});
    chk("R9 swhrq",      {15'd0, rd_data[6]}, {15'd0, m_hrq});
    chk("R8 hold",       {15'd0, hold_ack_eff}, {15'd0, m_psd ? m_hlda : hw_hold_ack});
    chk("R10 irq",       {15'd0, dma_irq}, {15'd0, m_hrq & ~m_hlda & m_sint});
  endtask

  task automatic do_reset(input logic bs, input logic ps);
    @(negedge clk);
    rst_n = 1'b0; boot_strap = bs; parity_strap = ps;
    wr_en = 0; dma_req = 0; dma_done = 0;
    @(posedge clk); @(negedge clk);
    rst_n = 1'b1;
    m_hlda = 0; m_hrq = 0; m_psd = 0; m_arst = 0; m_halt = bs; m_boot = bs;
    m_lbp = 0; m_sint = 1; m_pen = ps; m_n0 = 0; m_n1 = 1;
    // R1 reset state
    chk("R1 reset value", rd_data & 16'hFFD8,
        {1'b1, 1'b0, ps, 1'b1, 1'b0, bs, bs, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0});
    check_all();
  endtask

  task automatic step(input logic we, input logic [15:0] wd, input logic rq, input logic dn);
    logic old_arst, old_psd;
    @(negedge clk);
    wr_en = we; wr_data = wd; dma_req = rq; dma_done = dn;
    @(posedge clk);
    old_arst = m_arst; old_psd = m_psd;
    if (we) begin
      m_arst = wd[8]; m_lbp = wd[11]; m_sint = wd[12];
      if (wd[7]) m_psd = 1'b1;
      if (old_arst) begin
        m_halt = wd[9]; m_boot = wd[10]; m_pen = wd[13]; m_n0 = wd[14]; m_n1 = wd[15];
        m_hlda = wd[4] & old_psd;
      end
    end
    if (dn || (we && wd[8])) m_hrq = 1'b0;
    else if (rq && old_psd)  m_hrq = 1'b1;
    #5;
    wr_en = 0; dma_req = 0; dma_done = 0;
    check_all();
  endtask

  initial begin
    for (int i = 0; i < 4; i++) do_reset(i[0], i[1]);
    // R3 strap sweep with both directions
    for (int s = 0; s < 16; s++) begin
      @(negedge clk);
      strap_net = s[2:0]; xfer_dir = s[3];
      #1;
      chk("R3 net_type", {13'd0, net_type}, {13'd0, s[2] ? 3'd1 + {1'b0, s[0], s[1]} : 3'd0});
      check_all();
    end
    // write sweep: first with pseudo-DMA held off, then free
    for (int n = 0; n < 400; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      hw_hold_ack = lf[3] ^ lf[9];
      strap_net   = lf[2:0] ^ lf[14:12];
      xfer_dir    = lf[5];
      step(lf[0] | lf[1], (n < 120) ? (lf & 16'hFF7F) : lf, lf[6] & lf[2], lf[11] & lf[13] & lf[1]);
    end
    // R9 directed: set then simultaneous set and clear
    step(1'b1, 16'h1080, 1'b0, 1'b0);
    step(1'b0, 16'h0000, 1'b1, 1'b0);
    chk("R9 set by request", {15'd0, rd_data[6]}, 16'd1);
    step(1'b0, 16'h0000, 1'b1, 1'b1);
    chk("R9 clear wins", {15'd0, rd_data[6]}, 16'd0);
    step(1'b0, 16'h0000, 1'b1, 1'b0);
    step(1'b1, 16'h1180, 1'b1, 1'b0);
    chk("R9 areset write clears", {15'd0, rd_data[6]}, 16'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule